// File: doc/BRIEF.md
# Serial Flash Status-Register Write Engine

This block is the device-side command logic that a serial flash uses to manage its 16-bit status register. It watches a chip-select line and a stream of serial clock strobes that are already in the system clock domain. It decodes three commands: set write-enable, write status, and read the low status byte. It works either one bit per strobe or one nibble per strobe.

A status write is framed by chip-select. The engine counts the data bits as they arrive. When chip-select rises it decides whether the command commits. A commit needs the correct opcode, a data length of exactly one or two bytes, the write-enable latch set, no write cycle already running, and no hardware lock. A committed write starts a self-timed busy window of a fixed number of system clocks. At the end of that window the busy flag and the write-enable latch both drop. The host can poll the busy flag at any time with the read command, including during the busy window.

Top module: `sflash_status_writer`

## Requirements
- R1: After reset `statusOut` is 16'h0000 and `ioOe` is 0.
- R2: The opcode 8'h06, framed by exactly 8 bits, sets the write-enable latch (bit 1) when bit 0 (busy) is clear.
- R3: The opcode 8'h01 followed by exactly 16 data bits loads the bits of mask 16'h7BFC from the data. The first data byte is status bits 7..0 and the second is bits 15..8, each sent MSB first. Bits 15, 10, 1 and 0 are never taken from the data.
- R4: The opcode 8'h01 followed by exactly 8 data bits loads status bits 7..2 from the data. It forces bits 14, 9 and 8 to 0 and keeps bits 15, 13..10, 1 and 0.
- R5: A status write with any data length other than 8 or 16 bits leaves the register unchanged when chip-select rises.
- R6: A status write while the write-enable latch is 0 leaves the register unchanged.
- R7: A committed write sets bit 0 on the clock at which chip-select is seen high. Bit 0 stays 1 for exactly TW clocks, then bit 0 and bit 1 both clear on the same clock.
- R8: After opcode 8'h05, `ioOe` is 1 and the low status byte is presented MSB first, one bit per strobe, on `ioOut[1]`. The value is the live register, so the busy flag can be polled during a write cycle.
- R9: When bit 8 is 0, bit 7 is 1 and `wpN` is low, status writes are ignored. With `wpN` high the same write commits.
- R10: While bit 0 is 1, a new status write is rejected and the register is unchanged.
- R11: When `quadEn` is 1, each strobe carries one nibble on `dIn[3:0]`, high nibble of each byte first. The opcode takes 2 strobes and each data byte takes 2. The read data comes out on `ioOut[3:0]` in the same nibble order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select; a rise closes the command |
| shiftEn | input | 1 | One-cycle strobe per serial clock edge |
| quadEn | input | 1 | 1 selects four-bit transfers |
| dIn | input | 4 | Serial input; bit 0 only in single-bit mode |
| wpN | input | 1 | Active-low write-protect pin |
| ioOut | output | 4 | Read data; bit 1 in single-bit mode, all four in quad mode |
| ioOe | output | 1 | Output enable for `ioOut` during a status read |
| statusOut | output | 16 | Current status register |

## Verification
Some properties are checked on every cycle. The busy flag never stands without the write-enable latch. The fall of the busy flag always takes the latch with it. Bits 15 and 10 never move. No status bit above bit 1 changes while chip-select stays low. A busy cycle only starts when the latch was set and the hardware lock was off. The bench scenarios cover the rest: the exact masks applied by one- and two-byte writes, rejection of wrong data lengths, the exact length of the busy window, and bit and nibble ordering in both modes, including reads taken during a busy window.

// File: rtl/sflash_status_pkg.sv
package sflash_status_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;

  localparam int OPC_BITS    = 8;
  localparam int FRAME_SHORT = 16;
  localparam int FRAME_LONG  = 24;
  localparam int CNT_W       = $clog2(FRAME_LONG + 1);

  // bits a two-byte write may load
  localparam logic [15:0] WR_MASK   = 16'h7BFC;
  // bits a one-byte write may load from data
  localparam logic [15:0] LOW_MASK  = 16'h00FC;
  // upper control bits forced low by a one-byte write
  localparam logic [15:0] SHORT_CLR = 16'h4300;

  typedef struct packed {
    logic shift;
    logic clear;
    logic doWren;
    logic doWr8;
    logic doWr16;
  } srwStrobes_t;

endpackage

// File: rtl/sflash_status_ctrl.sv
module sflash_status_ctrl
  import sflash_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             shiftEn,
  input  logic             wpN,
  input  logic [7:0]       opCode,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             overrun,
  input  logic             wel,
  input  logic             wip,
  input  logic             srp0,
  input  logic             srp1,
  output srwStrobes_t      stb
);

  logic csPrev;
  logic csRise;
  logic hwLock;
  logic wrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrev <= 1'b1;
    else       csPrev <= csN;
  end

  assign csRise = csN & ~csPrev;
  assign hwLock = ~srp1 & srp0 & ~wpN;
  assign wrOk   = csRise & ~overrun & (opCode == OP_WRSR) & wel & ~wip & ~hwLock;

  always_comb begin
    stb        = '0;
    stb.shift  = shiftEn & ~csN;
    stb.clear  = csN;
    stb.doWr8  = wrOk & (bitCnt == CNT_W'(FRAME_SHORT));
    stb.doWr16 = wrOk & (bitCnt == CNT_W'(FRAME_LONG));
    stb.doWren = csRise & ~overrun & ~wip & (opCode == OP_WREN)
               & (bitCnt == CNT_W'(OPC_BITS));
  end

endmodule

// File: rtl/sflash_status_datapath.sv
module sflash_status_datapath
  import sflash_status_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  srwStrobes_t      stb,
  input  logic             quadEn,
  input  logic [3:0]       dIn,
  output logic [7:0]       opCode,
  output logic [CNT_W-1:0] bitCnt,
  output logic             overrun,
  output logic [15:0]      status,
  output logic [3:0]       ioOut,
  output logic             ioOe
);

  localparam int TMR_W = $clog2(TW + 1);

  logic [15:0]    shReg;
  logic [TMR_W-1:0] busyCnt;
  logic [CNT_W:0] cntNext;
  logic [15:0]    wordLong;
  logic [15:0]    wordShort;
  logic [2:0]     rdIdx;
  logic [7:0]     lowByte;

  assign cntNext   = {1'b0, bitCnt} + (quadEn ? (CNT_W+1)'(4) : (CNT_W+1)'(1));
  assign wordLong  = {shReg[7:0], shReg[15:8]};
  assign wordShort = {8'h00, shReg[7:0]};

  // bit counter, shift register, opcode capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      overrun <= 1'b0;
      shReg   <= '0;
      opCode  <= '0;
    end else if (stb.clear) begin
      bitCnt  <= '0;
      overrun <= 1'b0;
      opCode  <= '0;
    end else if (stb.shift) begin
      bitCnt <= cntNext[CNT_W-1:0];
      if (cntNext > (CNT_W+1)'(FRAME_LONG)) overrun <= 1'b1;
      if (quadEn) shReg <= {shReg[11:0], dIn};
      else        shReg <= {shReg[14:0], dIn[0]};
      if (cntNext == (CNT_W+1)'(OPC_BITS) && !overrun)
        opCode <= quadEn ? {shReg[3:0], dIn} : {shReg[6:0], dIn[0]};
    end
  end

  // status register and busy timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status  <= '0;
      busyCnt <= '0;
    end else if (stb.doWr16) begin
      status  <= (status & ~WR_MASK) | (wordLong & WR_MASK) | 16'h0001;
      busyCnt <= TMR_W'(TW);
    end else if (stb.doWr8) begin
      status  <= (status & ~(SHORT_CLR | LOW_MASK)) | (wordShort & LOW_MASK) | 16'h0001;
      busyCnt <= TMR_W'(TW);
    end else if (stb.doWren) begin
      status[1] <= 1'b1;
    end else if (status[0]) begin
      busyCnt <= busyCnt - 1'b1;
      if (busyCnt == TMR_W'(1)) status[1:0] <= 2'b00;
    end
  end

  // live read-out of the low status byte
  assign lowByte = status[7:0];
  assign rdIdx   = bitCnt[2:0];
  assign ioOe    = (opCode == OP_RDSR) & ~stb.clear;

  always_comb begin
    if (quadEn) ioOut = rdIdx[2] ? lowByte[3:0] : lowByte[7:4];
    else        ioOut = {2'b00, lowByte[~rdIdx], 1'b0};
  end

endmodule

// File: rtl/sflash_status_writer.sv
module sflash_status_writer
  import sflash_status_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        shiftEn,
  input  logic        quadEn,
  input  logic [3:0]  dIn,
  input  logic        wpN,
  output logic [3:0]  ioOut,
  output logic        ioOe,
  output logic [15:0] statusOut
);

  srwStrobes_t      stb;
  logic [7:0]       opCode;
  logic [CNT_W-1:0] bitCnt;
  logic             overrun;
  logic [15:0]      status;

  sflash_status_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .shiftEn (shiftEn),
    .wpN     (wpN),
    .opCode  (opCode),
    .bitCnt  (bitCnt),
    .overrun (overrun),
    .wel     (status[1]),
    .wip     (status[0]),
    .srp0    (status[7]),
    .srp1    (status[8]),
    .stb     (stb)
  );

  sflash_status_datapath #(.TW(TW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .quadEn  (quadEn),
    .dIn     (dIn),
    .opCode  (opCode),
    .bitCnt  (bitCnt),
    .overrun (overrun),
    .status  (status),
    .ioOut   (ioOut),
    .ioOe    (ioOe)
  );

  assign statusOut = status;

endmodule

// File: rtl/sflash_status_writer_chk.sv
module sflash_status_writer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        wpN,
  input logic [15:0] statusOut
);

  AST_WIP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[0] |-> statusOut[1]); // R7

  AST_FALL_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[0]) |-> !statusOut[1]); // R7

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    $stable({statusOut[15], statusOut[10]})); // R3

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[0]) |-> ($past(statusOut[1])
      && !$past(!statusOut[8] && statusOut[7] && !wpN))); // R6 R9

  AST_HOLD_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> $stable(statusOut[15:2])); // R5

endmodule

bind sflash_status_writer sflash_status_writer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .wpN       (wpN),
  .statusOut (statusOut)
);

// File: tb/sflash_status_writer_tb.sv
module sflash_status_writer_tb;

  localparam int TW = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        shiftEn = 1'b0;
  logic        quadEn = 1'b0;
  logic [3:0]  dIn = 4'h0;
  logic        wpN = 1'b1;
  logic [3:0]  ioOut;
  logic        ioOe;
  logic [15:0] statusOut;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  sflash_status_writer #(.TW(TW)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .shiftEn(shiftEn), .quadEn(quadEn),
    .dIn(dIn), .wpN(wpN), .ioOut(ioOut), .ioOe(ioOe), .statusOut(statusOut)
  );

  // {quad, opcode, data bits, data word (low byte sent first), wpN}
  localparam logic [30:0] VEC [12] = '{
    {1'b0, 8'h06, 5'd0,  16'h0000, 1'b1},
    {1'b0, 8'h01, 5'd16, 16'hFFFF, 1'b1},
    {1'b0, 8'h01, 5'd16, 16'hFFFF, 1'b1},
    {1'b0, 8'h06, 5'd0,  16'h0000, 1'b1},
    {1'b0, 8'h01, 5'd8,  16'h0084, 1'b1},
    {1'b0, 8'h06, 5'd0,  16'h0000, 1'b1},
    {1'b0, 8'h01, 5'd12, 16'h0FFF, 1'b1},
    {1'b0, 8'h01, 5'd16, 16'hFFFF, 1'b0},
    {1'b1, 8'h01, 5'd16, 16'h1234, 1'b1},
    {1'b1, 8'h06, 5'd0,  16'h0000, 1'b1},
    {1'b1, 8'h01, 5'd24, 16'h5555, 1'b1},
    {1'b1, 8'h01, 5'd8,  16'h00F0, 1'b1}
  };
  string rowTag [12] = '{"R2", "R3", "R6", "R2", "R4", "R2",
                         "R5", "R9", "R11", "R11", "R5", "R4"};

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] cur, input logic [7:0] op,
                                        input int n, input logic [15:0] dw, input logic wp);
    logic lock;
    lock = !cur[8] && cur[7] && !wp;
    model = cur;
    if (op == 8'h06 && n == 0 && !cur[0]) model = cur | 16'h0002;
    if (op == 8'h01 && cur[1] && !cur[0] && !lock) begin
      if (n == 16) model = (cur & ~16'h7BFC) | (dw & 16'h7BFC) | 16'h0001;
      if (n == 8)  model = (cur & ~16'h43FC) | (dw & 16'h00FC) | 16'h0001;
    end
  endfunction

  task automatic send(input logic q, input logic [7:0] op, input int n, input logic [15:0] dw);
    logic [31:0] v;
    int total;
    v = {op, dw[7:0], dw[15:8], 8'h00};
    total = 8 + n;
    quadEn = q;
    for (int i = 0; i < (q ? total / 4 : total); i++) begin
      @(negedge clk);
      csN = 1'b0;
      shiftEn = 1'b1;
      dIn = q ? v[31:28] : {3'b000, v[31]};
      v = q ? (v << 4) : (v << 1);
    end
    @(negedge clk);
    shiftEn = 1'b0;
    csN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readLow(input logic q, output logic [7:0] val, output logic oeSeen);
    logic [7:0] op;
    op = 8'h05;
    val = '0;
    oeSeen = 1'b1;
    quadEn = q;
    for (int i = 0; i < (q ? 2 : 8); i++) begin
      @(negedge clk);
      csN = 1'b0;
      shiftEn = 1'b1;
      dIn = q ? (i == 0 ? op[7:4] : op[3:0]) : {3'b000, op[7 - i]};
    end
    for (int i = 0; i < (q ? 2 : 8); i++) begin
      @(negedge clk);
      if (!ioOe) oeSeen = 1'b0;
      if (q) val = {val[3:0], ioOut};
      else   val = {val[6:0], ioOut[1]};
      shiftEn = 1'b1;
      dIn = 4'h0;
    end
    @(negedge clk);
    shiftEn = 1'b0;
    csN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] cur, exp, fin;
    logic [7:0]  rd;
    logic        oe;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(statusOut == 16'h0000, "R1 status", statusOut, 16'h0000);
    chk(ioOe == 1'b0, "R1 ioOe", {15'd0, ioOe}, 16'h0000);
    cur = 16'h0000;

    foreach (VEC[i]) begin
      wpN = VEC[i][0];
      exp = model(cur, VEC[i][29:22], int'(VEC[i][21:17]), VEC[i][16:1], VEC[i][0]);
      send(VEC[i][30], VEC[i][29:22], int'(VEC[i][21:17]), VEC[i][16:1]);
      chk(statusOut == exp, rowTag[i], statusOut, exp);
      repeat (TW - 1) @(negedge clk);
      chk(statusOut[0] == exp[0], "R7 busy held", statusOut, exp);
      @(negedge clk);
      fin = exp[0] ? (exp & ~16'h0003) : exp;
      chk(statusOut == fin, "R7 cycle end", statusOut, fin);
      cur = fin;
      wpN = 1'b1;
    end

    // busy window: live polling and rejection of a second write
    send(1'b0, 8'h06, 0, 16'h0000);
    cur = model(cur, 8'h06, 0, 16'h0000, 1'b1);
    chk(statusOut == cur, "R2 enable", statusOut, cur);
    exp = model(cur, 8'h01, 16, 16'h00A8, 1'b1);
    send(1'b0, 8'h01, 16, 16'h00A8);
    chk(statusOut == exp, "R3 commit", statusOut, exp);
    readLow(1'b0, rd, oe);
    chk(rd == exp[7:0], "R8 poll busy", {8'h00, rd}, {8'h00, exp[7:0]});
    chk(oe, "R8 ioOe", {15'd0, oe}, 16'h0001);
    send(1'b0, 8'h01, 16, 16'hFFFF);
    chk(statusOut == exp, "R10 busy reject", statusOut, exp);
    repeat (TW) @(negedge clk);
    fin = exp & ~16'h0003;
    chk(statusOut == fin, "R7 after busy", statusOut, fin);
    readLow(1'b0, rd, oe);
    chk(rd == fin[7:0], "R8 idle read", {8'h00, rd}, {8'h00, fin[7:0]});
    readLow(1'b1, rd, oe);
    chk(rd == fin[7:0], "R11 quad read", {8'h00, rd}, {8'h00, fin[7:0]});
    chk(oe, "R11 ioOe", {15'd0, oe}, 16'h0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule